// File: doc/BRIEF.md
# Checkpoint and Rollback Controller

This controller protects a processing unit against soft errors by saving its architectural state at regular intervals and putting that state back when the detection logic reports a fault. The saved state is the program counter, the register file and a small data memory. The unit exposes all of it as one flat space of words. The controller reads and writes this space one word per cycle. It copies each word into an external checkpoint store, which is split into two banks. A new checkpoint never overwrites the one that is still valid.

One programmable period sets how often checkpoints are taken. A period of zero makes checkpointing continuous, so the recovery point is only as old as one state transfer. When an error is reported, the controller holds the unit stalled and raises a repair request to the configuration repair logic. It waits for the repair-done input, then copies the last complete checkpoint back into the unit and lets execution resume from that point. If an error arrives before any checkpoint has completed, the controller raises a sticky fatal flag and does not attempt a restore.

The controller has six states, reported on `state_o`:

| State | Code | What it does | Transitions out |
|---|---|---|---|
| IDLE | 0 | Off | Goes to WAIT_PERIOD when enabled and not fatal. |
| WAIT_PERIOD | 1 | Counts the period | Goes to SAVE when the period expires. Goes back to IDLE when disabled. |
| SAVE | 2 | Copies the unit's state into the store | Goes back to WAIT_PERIOD after the last word. |
| WAIT_REPAIR | 3 | Waits for configuration repair | Goes to RESTORE on repair done. |
| RESTORE | 4 | Copies the checkpoint back into the unit | Goes to RESUME after the last word. |
| RESUME | 5 | Lasts one cycle | Goes back to WAIT_PERIOD. |

Error transitions:
- An error in WAIT_PERIOD or SAVE goes to WAIT_REPAIR when a valid checkpoint exists. Otherwise it goes to IDLE and sets the fatal flag.
- An error in RESTORE or RESUME goes back to WAIT_REPAIR.

Top module: `ckpt_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (IDLE), and `stall_req`, `repair_req`, `ckpt_valid` and `fatal` are 0. Both counters are 0.
- R2: In IDLE with `en` high, the next state is WAIT_PERIOD (1). WAIT_PERIOD lasts `cfg_period`+1 cycles and then moves to SAVE (2). Dropping `en` in WAIT_PERIOD returns the controller to IDLE.
- R3: With `cfg_period` = 0, each SAVE that completes is followed by exactly one WAIT_PERIOD cycle and then another SAVE.
- R4: `stall_req` is high in SAVE, WAIT_REPAIR, RESTORE and RESUME. No word moves (`unit_we` and `store_we` stay low) in any cycle where `stall_ack` is low.
- R5: Word indices are laid out as follows: index 0 is the program counter, indices 1 to NREG are the registers, and the data memory follows. A save writes unit word i to store address b*NW+i, where NW = 1+NREG+NMEM. Bank b is the bank not holding the valid checkpoint; after reset bank 0 counts as holding it. On the last word, `ckpt_valid` becomes 1, `ckpt_count` increments and the banks swap roles.
- R6: An error during SAVE abandons that save. `ckpt_count` does not change, and a later restore returns the contents of the previous complete checkpoint.
- R7: An error while a valid checkpoint exists moves the controller to WAIT_REPAIR (3) with `repair_req` high. It stays there, and writes nothing into the unit, until `repair_done` is seen.
- R8: RESTORE (4) writes every word of the valid bank back into the unit at the same index. It is followed by one RESUME (5) cycle, in which `rollback_count` increments, and then WAIT_PERIOD with `stall_req` low.
- R9: An error in WAIT_PERIOD or SAVE before any checkpoint is valid sets `fatal`. The state goes to IDLE and stays there, ignoring `en`, until reset. No restore takes place.
- R10: Both counters saturate at their maximum value instead of wrapping.
- R11: An error in IDLE has no effect: the state stays 0 and `fatal` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enables periodic checkpointing |
| cfg_period | input | PER_W | Number of idle cycles between checkpoints, minus one wait cycle |
| err_in | input | 1 | Error reported by the user-logic detection |
| repair_done | input | 1 | Configuration repair has finished |
| repair_req | output | 1 | Requests configuration repair |
| stall_req | output | 1 | Asks the protected unit to freeze |
| stall_ack | input | 1 | The protected unit is frozen |
| unit_addr | output | IDX_W | Word index into the unit's state |
| unit_we | output | 1 | Writes `unit_wdata` into the unit's state |
| unit_wdata | output | DATA_W | Word being restored into the unit |
| unit_rdata | input | DATA_W | Unit state word at `unit_addr` (combinational read) |
| store_addr | output | SA_W | Checkpoint store address |
| store_we | output | 1 | Writes `store_wdata` into the store |
| store_wdata | output | DATA_W | Word being saved |
| store_rdata | input | DATA_W | Store word at `store_addr` (combinational read) |
| state_o | output | 3 | Current state code |
| ckpt_valid | output | 1 | At least one complete checkpoint exists |
| fatal | output | 1 | Error with no checkpoint to return to |
| ckpt_count | output | CNT_W | Completed checkpoints, saturating |
| rollback_count | output | CNT_W | Rollbacks performed, saturating |

## Verification
The bench aims at six corner cases:
- An error part-way through a save. A design that commits early or writes over the live bank would restore a mix of old and new words.
- A delayed stall acknowledge. A controller that ignores it would copy words from a unit that is still running.
- Zero period, where an off-by-one in the timer shows up as a missing or extra wait cycle.
- A long hold in repair. A controller that restores early would write back state before the configuration is fixed.
- An error before the first checkpoint, which must end in the fatal flag rather than a restore from an empty store.
- Counter saturation, where a wrapping counter would fall back to zero.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT    = 3'd1,
        ST_SAVE    = 3'd2,
        ST_REPAIR  = 3'd3,
        ST_RESTORE = 3'd4,
        ST_RESUME  = 3'd5
    } ckpt_state_e;
endpackage

// File: rtl/ckpt_period_timer.sv
module ckpt_period_timer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] cfg_period,
    output logic             expired
);
    logic [PER_W-1:0] cnt_q;

    assign expired = (cnt_q >= cfg_period);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the count only climbs while it runs and has not reached the period
    assert_timer_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/ckpt_word_seq.sv
module ckpt_word_seq #(
    parameter int NW    = 13,
    parameter int IDX_W = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NW - 1);

    logic [IDX_W-1:0] idx_q;

    assign idx  = idx_q;
    assign last = (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= last ? '0 : idx_q + 1'b1;
        end
    end

    // R5: the word index never leaves the state space
    assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_IDX);
endmodule

// File: rtl/ckpt_event_cnt.sv
module ckpt_event_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP) |=> (cnt_q == TOP));
endmodule

// File: rtl/ckpt_ctrl.sv
module ckpt_ctrl
    import ckpt_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 4,
    parameter int NMEM   = 8,
    parameter int PER_W  = 16,
    parameter int CNT_W  = 8,
    localparam int NW    = 1 + NREG + NMEM,
    localparam int IDX_W = (NW > 1) ? $clog2(NW) : 1,
    localparam int SA_W  = $clog2(2 * NW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic              err_in,
    input  logic              repair_done,
    output logic              repair_req,
    output logic              stall_req,
    input  logic              stall_ack,
    output logic [IDX_W-1:0]  unit_addr,
    output logic              unit_we,
    output logic [DATA_W-1:0] unit_wdata,
    input  logic [DATA_W-1:0] unit_rdata,
    output logic [SA_W-1:0]   store_addr,
    output logic              store_we,
    output logic [DATA_W-1:0] store_wdata,
    input  logic [DATA_W-1:0] store_rdata,
    output logic [2:0]        state_o,
    output logic              ckpt_valid,
    output logic              fatal,
    output logic [CNT_W-1:0]  ckpt_count,
    output logic [CNT_W-1:0]  rollback_count
);
    localparam logic [SA_W-1:0] BANK1_BASE = SA_W'(NW);

    ckpt_state_e      st_q, st_nxt;
    logic             valid_q;
    logic             fatal_q;
    logic             bank_q;      // bank holding the valid checkpoint
    logic             expired;
    logic [IDX_W-1:0] idx;
    logic             last;
    logic             xfer;
    logic             save_done;
    logic             rb_inc;
    logic             err_live;
    logic             set_fatal;

    // error matters only where the unit runs or is being refilled
    assign err_live  = err_in && (st_q == ST_WAIT || st_q == ST_SAVE ||
                                  st_q == ST_RESTORE || st_q == ST_RESUME);
    assign set_fatal = err_in && !valid_q && (st_q == ST_WAIT || st_q == ST_SAVE);
    assign xfer      = stall_ack && (st_q == ST_SAVE || st_q == ST_RESTORE);
    assign save_done = (st_q == ST_SAVE) && stall_ack && last && !err_in;
    assign rb_inc    = (st_q == ST_RESUME);

    ckpt_period_timer #(.PER_W(PER_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (st_q == ST_WAIT),
        .cfg_period (cfg_period),
        .expired    (expired)
    );

    ckpt_word_seq #(.NW(NW), .IDX_W(IDX_W)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (st_nxt != st_q),
        .step  (xfer),
        .idx   (idx),
        .last  (last)
    );

    ckpt_event_cnt #(.W(CNT_W)) u_ckpt_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (save_done),
        .count (ckpt_count)
    );

    ckpt_event_cnt #(.W(CNT_W)) u_rb_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rb_inc),
        .count (rollback_count)
    );

    // next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (en && !fatal_q) st_nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (err_live)     st_nxt = valid_q ? ST_REPAIR : ST_IDLE;
                else if (!en)     st_nxt = ST_IDLE;
                else if (expired) st_nxt = ST_SAVE;
            end
            ST_SAVE: begin
                if (err_live)                st_nxt = valid_q ? ST_REPAIR : ST_IDLE;
                else if (stall_ack && last)  st_nxt = ST_WAIT;
            end
            ST_REPAIR: begin
                if (repair_done) st_nxt = ST_RESTORE;
            end
            ST_RESTORE: begin
                if (err_live)               st_nxt = ST_REPAIR;
                else if (stall_ack && last) st_nxt = ST_RESUME;
            end
            ST_RESUME: begin
                st_nxt = err_live ? ST_REPAIR : ST_WAIT;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // state register and checkpoint bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            valid_q <= 1'b0;
            fatal_q <= 1'b0;
            bank_q  <= 1'b0;
        end else begin
            st_q <= st_nxt;
            if (set_fatal) fatal_q <= 1'b1;
            if (save_done) begin
                valid_q <= 1'b1;
                bank_q  <= ~bank_q;
            end
        end
    end

    // outputs
    always_comb begin
        state_o     = st_q;
        stall_req   = 1'b0;
        repair_req  = 1'b0;
        unit_we     = 1'b0;
        store_we    = 1'b0;
        unit_addr   = idx;
        unit_wdata  = store_rdata;
        store_wdata = unit_rdata;
        store_addr  = SA_W'(idx);
        unique case (st_q)
            ST_IDLE, ST_WAIT: ;
            ST_SAVE: begin
                stall_req  = 1'b1;
                store_we   = stall_ack;
                store_addr = (bank_q ? '0 : BANK1_BASE) + SA_W'(idx);
            end
            ST_REPAIR: begin
                stall_req  = 1'b1;
                repair_req = 1'b1;
            end
            ST_RESTORE: begin
                stall_req  = 1'b1;
                unit_we    = stall_ack;
                store_addr = (bank_q ? BANK1_BASE : '0) + SA_W'(idx);
            end
            ST_RESUME: begin
                stall_req  = 1'b1;
            end
            default: ;
        endcase
    end

    assign ckpt_valid = valid_q;
    assign fatal      = fatal_q;

    // assertions
    assert_xfer_needs_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_we || store_we) |-> (stall_ack && stall_req));

    assert_wait_to_save_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && expired && en && !err_in) |=> (st_q == ST_SAVE));

    assert_repair_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REPAIR && !repair_done) |=> (st_q == ST_REPAIR && !unit_we));

    assert_fatal_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_q |=> (fatal_q && st_q == ST_IDLE));

    assert_restore_needs_ckpt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RESTORE) |-> valid_q);

    assert_abort_no_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SAVE && err_in) |=> $stable(ckpt_count));

    assert_resume_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RESUME) |=> (st_q != ST_RESUME));
endmodule

// File: tb/ckpt_ctrl_tb.sv
module ckpt_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int NREG   = 4;
    localparam int NMEM   = 8;
    localparam int PER_W  = 8;
    localparam int CNT_W  = 3;
    localparam int NW     = 1 + NREG + NMEM;
    localparam int IDX_W  = $clog2(NW);
    localparam int SA_W   = $clog2(2 * NW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [PER_W-1:0] cfg_period = '0;
    logic err_in = 1'b0;
    logic repair_done = 1'b0;
    logic repair_req, stall_req;
    logic stall_ack = 1'b0;
    logic ack_block = 1'b0;
    logic [IDX_W-1:0] unit_addr;
    logic unit_we;
    logic [DATA_W-1:0] unit_wdata, unit_rdata;
    logic [SA_W-1:0] store_addr;
    logic store_we;
    logic [DATA_W-1:0] store_wdata, store_rdata;
    logic [2:0] state_o;
    logic ckpt_valid, fatal;
    logic [CNT_W-1:0] ckpt_count, rollback_count;

    logic [DATA_W-1:0] unit_m [NW];
    logic [DATA_W-1:0] store_m [2*NW];
    logic [DATA_W-1:0] snap [NW];

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ckpt_ctrl #(.DATA_W(DATA_W), .NREG(NREG), .NMEM(NMEM), .PER_W(PER_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_period(cfg_period), .err_in(err_in),
        .repair_done(repair_done), .repair_req(repair_req), .stall_req(stall_req),
        .stall_ack(stall_ack), .unit_addr(unit_addr), .unit_we(unit_we),
        .unit_wdata(unit_wdata), .unit_rdata(unit_rdata), .store_addr(store_addr),
        .store_we(store_we), .store_wdata(store_wdata), .store_rdata(store_rdata),
        .state_o(state_o), .ckpt_valid(ckpt_valid), .fatal(fatal),
        .ckpt_count(ckpt_count), .rollback_count(rollback_count)
    );

    // protected unit and checkpoint store models
    assign unit_rdata  = unit_m[unit_addr];
    assign store_rdata = store_m[store_addr];

    always @(posedge clk) begin
        if (unit_we) unit_m[unit_addr] <= unit_wdata;
        if (store_we) store_m[store_addr] <= store_wdata;
        stall_ack <= rst_n && stall_req && !ack_block;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_state(input logic [2:0] s, input string req);
        int n = 0;
        while (state_o != s && n < 2000) begin
            tick();
            n++;
        end
        check(req, {29'd0, state_o}, {29'd0, s});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        en = 1'b0;
        err_in = 1'b0;
        repair_done = 1'b0;
        ack_block = 1'b0;
        for (int i = 0; i < NW; i++) unit_m[i] = DATA_W'(16'h1000 + i);
        for (int i = 0; i < 2*NW; i++) store_m[i] = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic pulse_err();
        err_in = 1'b1;
        tick();
        err_in = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 state", {29'd0, state_o}, 32'd0);
        check("R1 stall", {31'd0, stall_req}, 32'd0);
        check("R1 repair", {31'd0, repair_req}, 32'd0);
        check("R1 valid", {31'd0, ckpt_valid}, 32'd0);
        check("R1 fatal", {31'd0, fatal}, 32'd0);
        check("R1 counts", {26'd0, ckpt_count, rollback_count}, 32'd0);
    endtask

    task automatic t_idle_err();
        pulse_err();
        tick();
        check("R11 state", {29'd0, state_o}, 32'd0);
        check("R11 fatal", {31'd0, fatal}, 32'd0);
    endtask

    task automatic t_early_fatal();
        cfg_period = 8'd20;
        en = 1'b1;
        tick();
        check("R2 enter wait", {29'd0, state_o}, 32'd1);
        pulse_err();
        check("R9 fatal", {31'd0, fatal}, 32'd1);
        check("R9 state idle", {29'd0, state_o}, 32'd0);
        for (int i = 0; i < 6; i++) tick();
        check("R9 stays idle", {29'd0, state_o}, 32'd0);
        check("R9 no rollback", {29'd0, rollback_count}, 32'd0);
        check("R9 no stall", {31'd0, stall_req}, 32'd0);
    endtask

    task automatic t_period_save();
        int n = 0;
        bit early_we = 0;
        cfg_period = 8'd5;
        en = 1'b1;
        tick();
        while (state_o == 3'd1 && n < 100) begin
            n++;
            tick();
        end
        check("R2 wait length", n, 32'd6);
        check("R2 save entered", {29'd0, state_o}, 32'd2);
        check("R4 stall in save", {31'd0, stall_req}, 32'd1);
        early_we = store_we;
        check("R4 no write before ack", {31'd0, early_we}, 32'd0);
        cfg_period = 8'd200;
        wait_state(3'd1, "R5 save finished");
        for (int i = 0; i < NW; i++) begin
            check("R5 bank1 copy", {16'd0, store_m[NW+i]}, {16'd0, unit_m[i]});
            snap[i] = unit_m[i];
        end
        check("R5 valid", {31'd0, ckpt_valid}, 32'd1);
        check("R5 count", {29'd0, ckpt_count}, 32'd1);
        en = 1'b0;
        tick();
        check("R2 disable to idle", {29'd0, state_o}, 32'd0);
        en = 1'b1;
        tick();
    endtask

    task automatic t_ack_block();
        bit moved = 0;
        bit left = 0;
        ack_block = 1'b1;
        cfg_period = 8'd0;
        wait_state(3'd2, "R4 save entered");
        cfg_period = 8'd200;
        for (int i = 0; i < 5; i++) begin
            if (store_we || unit_we) moved = 1;
            if (state_o != 3'd2) left = 1;
            tick();
        end
        check("R4 no transfer without ack", {31'd0, moved}, 32'd0);
        check("R4 held in save", {31'd0, left}, 32'd0);
        ack_block = 1'b0;
        wait_state(3'd1, "R4 save completes");
        check("R5 second count", {29'd0, ckpt_count}, 32'd2);
        for (int i = 0; i < NW; i++)
            check("R5 bank0 copy", {16'd0, store_m[i]}, {16'd0, unit_m[i]});
    endtask

    task automatic t_zero_period();
        int n = 0;
        cfg_period = 8'd0;
        wait_state(3'd2, "R3 save");
        wait_state(3'd1, "R3 back to wait");
        while (state_o == 3'd1 && n < 50) begin
            n++;
            tick();
        end
        check("R3 one wait cycle", n, 32'd1);
        check("R3 next save", {29'd0, state_o}, 32'd2);
        cfg_period = 8'd200;
        wait_state(3'd1, "R3 settle");
        for (int i = 0; i < NW; i++) snap[i] = unit_m[i];
    endtask

    task automatic t_rollback();
        bit touched = 0;
        for (int i = 0; i < NW; i++) unit_m[i] = DATA_W'(16'hBAD0 + i);
        pulse_err();
        check("R7 repair state", {29'd0, state_o}, 32'd3);
        check("R7 repair_req", {31'd0, repair_req}, 32'd1);
        for (int i = 0; i < 8; i++) tick();
        check("R7 held in repair", {29'd0, state_o}, 32'd3);
        for (int i = 0; i < NW; i++)
            if (unit_m[i] != DATA_W'(16'hBAD0 + i)) touched = 1;
        check("R7 no early write", {31'd0, touched}, 32'd0);
        repair_done = 1'b1;
        tick();
        repair_done = 1'b0;
        check("R8 restore state", {29'd0, state_o}, 32'd4);
        wait_state(3'd5, "R8 resume");
        for (int i = 0; i < NW; i++)
            check("R8 restored word", {16'd0, unit_m[i]}, {16'd0, snap[i]});
        tick();
        check("R8 back to wait", {29'd0, state_o}, 32'd1);
        check("R8 stall released", {31'd0, stall_req}, 32'd0);
        check("R8 rollback count", {29'd0, rollback_count}, 32'd1);
    endtask

    task automatic t_abort();
        logic [CNT_W-1:0] c0;
        c0 = ckpt_count;
        for (int i = 0; i < NW; i++) unit_m[i] = DATA_W'(16'h5500 + i);
        cfg_period = 8'd0;
        wait_state(3'd2, "R6 save started");
        cfg_period = 8'd200;
        for (int i = 0; i < 4; i++) tick();
        pulse_err();
        check("R6 to repair", {29'd0, state_o}, 32'd3);
        check("R6 count unchanged", {29'd0, ckpt_count}, {29'd0, c0});
        repair_done = 1'b1;
        tick();
        repair_done = 1'b0;
        wait_state(3'd5, "R6 resume");
        for (int i = 0; i < NW; i++)
            check("R6 previous checkpoint", {16'd0, unit_m[i]}, {16'd0, snap[i]});
        tick();
    endtask

    task automatic t_saturate();
        cfg_period = 8'd0;
        for (int i = 0; i < 200; i++) tick();
        cfg_period = 8'd200;
        wait_state(3'd1, "R10 settle");
        check("R10 saturated", {29'd0, ckpt_count}, 32'd7);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_idle_err();
        t_early_fatal();
        do_reset();
        t_period_save();
        t_ack_block();
        t_zero_period();
        t_rollback();
        t_abort();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule